// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Router

This block gathers the level-sensitive interrupt pins (INTA..INTD) of every device slot on a PCI bus and folds them onto four shared interrupt lines. A fixed board table assigns the on-board slots to lines. The four expansion slots rotate their pins so that the load spreads across the lines. Each shared line is the OR of every device pin that maps onto it.

Each shared line has a programmable 8-bit routing value that selects one of 16 legacy interrupt controller inputs. A controller input is asserted when any shared line routed to it is high. A routing value of 16 or more leaves its line connected to nothing. The routing values are loaded through a simple index/value write port. The 16-bit request vector is registered, so it lags the pins and the routing registers by one clock.

Top module: `pci_irq_router`

## Requirements
- R1: While reset is active and after it, until a routing value is written, all four routing values hold 0x80 and irq_o is all zeros, whatever the pin levels are.
- R2: Every pin of slot 10 drives shared line 3. Every pin of slot 11 drives line 1. Every pin of slot 12 drives line 2.
- R3: For slots 18 to 21, pin p (0=INTA .. 3=INTD) drives shared line ((slot - 18) + p) mod 4.
- R4: For every other slot, pin p drives shared line p.
- R5: A shared line is high while at least one pin mapped onto it is high. Pin s*4+p of pin_lvl_i is pin p of slot s.
- R6: A write with route_we_i high stores route_val_i into the routing value of line route_idx_i at that clock edge. The other three routing values are left unchanged.
- R7: A routing value of 16 or more connects its line to no controller input. Values 16 and 255 both disconnect the line, and value 15 selects input 15.
- R8: Bit i of irq_o is the OR of all shared lines whose routing value equals i. Several lines may share one input.
- R9: irq_o is registered. A pin change is visible after the next rising edge. A change to a routing value is visible after the rising edge that follows the edge storing it.
- R10: The outputs follow the pin levels in both directions. Dropping the last active pin of a line clears the routed bit one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_lvl_i | input | NUM_SLOTS*4 (128) | Device interrupt levels, bit s*4+p = slot s pin p |
| route_we_i | input | 1 | Routing value write enable |
| route_idx_i | input | 2 | Shared line whose routing value is written |
| route_val_i | input | 8 | Routing value to write |
| irq_o | output | 16 | Registered controller input levels |

## Verification
A routing write and a pin change can fall in the same cycle. The bench provokes this by raising a slot-10 pin on the same clock edge that rewrites line 3's routing value. The first registered output must show the new pin level through the old routing, and the next output must show it through the new routing. The full slot-by-pin sweep checks the board table, the rotation and the pass-through case against a mapping computed in the bench.

// File: rtl/pci_irq_pkg.sv
package pci_irq_pkg;
  localparam int unsigned PCI_PINS   = 4;
  localparam int unsigned PCI_LINES  = 4;
  localparam int unsigned LINE_W     = 2;
  localparam int unsigned SLOT_USB   = 10;
  localparam int unsigned SLOT_NIC   = 11;
  localparam int unsigned SLOT_AUDIO = 12;
  localparam int unsigned EXP_FIRST  = 18;
  localparam int unsigned EXP_COUNT  = 4;

  // Board slot table and expansion-slot rotation.
  function automatic logic [LINE_W-1:0] slot_to_line(input int unsigned slot,
                                                     input int unsigned pin);
    int unsigned r;
    if (slot == SLOT_USB)        r = 3;
    else if (slot == SLOT_NIC)   r = 1;
    else if (slot == SLOT_AUDIO) r = 2;
    else if (slot >= EXP_FIRST && slot < EXP_FIRST + EXP_COUNT)
      r = ((slot - EXP_FIRST) + pin) % PCI_LINES;
    else
      r = pin % PCI_LINES;
    return LINE_W'(r);
  endfunction
endpackage

// File: rtl/pci_irq_swizzle.sv
module pci_irq_swizzle
  import pci_irq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 32,
  localparam int unsigned NPIN = NUM_SLOTS * PCI_PINS
) (
  input  logic [NPIN-1:0]      pin_lvl_i,
  output logic [PCI_LINES-1:0] line_o
);
  for (genvar l = 0; l < PCI_LINES; l++) begin : g_line
    logic [NPIN-1:0] sel;
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      for (genvar p = 0; p < PCI_PINS; p++) begin : g_pin
        assign sel[s*PCI_PINS+p] = (slot_to_line(s, p) == LINE_W'(l));
      end
    end
    assign line_o[l] = |(pin_lvl_i & sel);
  end
endmodule

// File: rtl/pci_irq_route_regs.sv
module pci_irq_route_regs #(
  parameter int unsigned N_LINES = 4,
  parameter int unsigned ROUTE_W = 8,
  parameter logic [ROUTE_W-1:0] RST_VAL = 8'h80,
  localparam int unsigned IDX_W = $clog2(N_LINES)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [ROUTE_W-1:0]              val_i,
  output logic [N_LINES-1:0][ROUTE_W-1:0] route_o
);
  for (genvar l = 0; l < N_LINES; l++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            route_o[l] <= RST_VAL;
      else if (we_i && idx_i == IDX_W'(l))    route_o[l] <= val_i;
    end
  end

  p_write_lands_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> route_o[$past(idx_i)] == $past(val_i));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(route_o));
endmodule

// File: rtl/pci_irq_route_matrix.sv
module pci_irq_route_matrix #(
  parameter int unsigned N_LINES  = 4,
  parameter int unsigned N_INPUTS = 16,
  parameter int unsigned ROUTE_W  = 8
) (
  input  logic [N_LINES-1:0]              line_i,
  input  logic [N_LINES-1:0][ROUTE_W-1:0] route_i,
  output logic [N_INPUTS-1:0]             req_o
);
  // Values >= N_INPUTS never match an input index, so the line is dropped.
  always_comb begin
    req_o = '0;
    for (int i = 0; i < N_INPUTS; i++) begin
      for (int l = 0; l < N_LINES; l++) begin
        if (line_i[l] && route_i[l] == ROUTE_W'(i)) req_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pci_irq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = 32,
  parameter int unsigned NUM_INPUTS = 16,
  parameter int unsigned ROUTE_W    = 8,
  parameter logic [ROUTE_W-1:0] ROUTE_RST = 8'h80,
  localparam int unsigned NPIN  = NUM_SLOTS * PCI_PINS,
  localparam int unsigned IDX_W = $clog2(PCI_LINES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NPIN-1:0]       pin_lvl_i,
  input  logic                  route_we_i,
  input  logic [IDX_W-1:0]      route_idx_i,
  input  logic [ROUTE_W-1:0]    route_val_i,
  output logic [NUM_INPUTS-1:0] irq_o
);
  logic [PCI_LINES-1:0]              line;
  logic [PCI_LINES-1:0][ROUTE_W-1:0] route;
  logic [NUM_INPUTS-1:0]             req;
  logic [PCI_LINES-1:0]              line_off;

  pci_irq_swizzle #(.NUM_SLOTS(NUM_SLOTS)) u_swz (
    .pin_lvl_i(pin_lvl_i),
    .line_o   (line)
  );

  pci_irq_route_regs #(
    .N_LINES(PCI_LINES), .ROUTE_W(ROUTE_W), .RST_VAL(ROUTE_RST)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (route_we_i),
    .idx_i  (route_idx_i),
    .val_i  (route_val_i),
    .route_o(route)
  );

  pci_irq_route_matrix #(
    .N_LINES(PCI_LINES), .N_INPUTS(NUM_INPUTS), .ROUTE_W(ROUTE_W)
  ) u_mtx (
    .line_i (line),
    .route_i(route),
    .req_o  (req)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else         irq_o <= req;
  end

  for (genvar l = 0; l < PCI_LINES; l++) begin : g_off
    assign line_off[l] = (route[l] >= ROUTE_W'(NUM_INPUTS));
  end

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_lvl_i == '0) |=> (irq_o == '0));

  p_all_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&line_off) |=> (irq_o == '0));

  p_fanin_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_o) <= PCI_LINES);

  p_line_needs_pin_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line != '0) |-> (pin_lvl_i != '0));
endmodule

// File: tb/sim_pci_irq_router.sv
module sim_pci_irq_router;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [NS*4-1:0] pins = '0;
  logic         we = 1'b0;
  logic [1:0]   idx = '0;
  logic [7:0]   val = '0;
  logic [15:0]  irq;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_irq_router u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_lvl_i(pins),
    .route_we_i(we), .route_idx_i(idx), .route_val_i(val), .irq_o(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_o=%h expected %h", req, act, exp);
    end
  endtask

  function automatic int exp_line(input int s, input int p);
    if (s == 10) return 3;
    if (s == 11) return 1;
    if (s == 12) return 2;
    if (s >= 18 && s <= 21) return (s - 18 + p) % 4;
    return p;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  // Write lands at the next posedge; output follows one edge later.
  task automatic wr_route(input logic [1:0] i, input logic [7:0] v);
    @(negedge clk); we = 1'b1; idx = i; val = v;
    @(negedge clk); we = 1'b0;
  endtask

  function automatic int pin_bit(input int s, input int p);
    return s * 4 + p;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: irq_o=%h expected completion", irq);
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    // R1: reset state, all pins high
    pins = '1;
    step(); step();
    check("R1 in reset", irq, 16'h0);
    rst_n = 1'b1;
    step(); step();
    check("R1 routes 0x80 after reset", irq, 16'h0);
    pins = '0;

    // Sweep: line l -> input 4+l
    for (int l = 0; l < 4; l++) wr_route(2'(l), 8'(4 + l));
    step();
    for (int s = 0; s < NS; s++) begin
      for (int p = 0; p < 4; p++) begin
        pins = '0;
        pins[pin_bit(s, p)] = 1'b1;
        step();
        if (s >= 10 && s <= 12)      check($sformatf("R2 slot %0d pin %0d", s, p), irq, 16'(1) << (4 + exp_line(s, p)));
        else if (s >= 18 && s <= 21) check($sformatf("R3 slot %0d pin %0d", s, p), irq, 16'(1) << (4 + exp_line(s, p)));
        else                         check($sformatf("R4 slot %0d pin %0d", s, p), irq, 16'(1) << (4 + exp_line(s, p)));
      end
    end

    // R5/R10: two pins sharing line 1
    pins = '0;
    pins[pin_bit(18, 1)] = 1'b1;
    pins[pin_bit(11, 3)] = 1'b1;
    step();
    check("R5 two pins one line", irq, 16'h0020);
    pins[pin_bit(18, 1)] = 1'b0;
    step();
    check("R5 one pin remaining", irq, 16'h0020);
    pins[pin_bit(11, 3)] = 1'b0;
    step();
    check("R10 line drops", irq, 16'h0000);

    // R9: pin latency
    @(negedge clk); pins[pin_bit(0, 0)] = 1'b1;
    #1 check("R9 pin not yet visible", irq, 16'h0000);
    step();
    check("R9 pin visible after one edge", irq, 16'h0010);
    pins = '0;
    step();

    // R8: lines 0 and 2 onto input 9, line 1 onto input 5
    wr_route(2'd0, 8'd9);
    wr_route(2'd2, 8'd9);
    wr_route(2'd1, 8'd5);
    pins[pin_bit(0, 0)] = 1'b1;   // line 0
    pins[pin_bit(12, 2)] = 1'b1;  // line 2
    step();
    check("R8 shared input", irq, 16'h0200);
    pins[pin_bit(0, 0)] = 1'b0;
    step();
    check("R8 shared input one source", irq, 16'h0200);
    pins[pin_bit(1, 1)] = 1'b1;   // line 1
    step();
    check("R8 mixed inputs", irq, 16'h0220);
    pins = '0;
    step();

    // R7: disconnect boundary
    pins[pin_bit(0, 0)] = 1'b1;
    wr_route(2'd0, 8'd16);
    step();
    check("R7 value 16 disconnects", irq, 16'h0000);
    wr_route(2'd0, 8'd15);
    step();
    check("R7 value 15 selects input 15", irq, 16'h8000);
    wr_route(2'd0, 8'd255);
    step();
    check("R7 value 255 disconnects", irq, 16'h0000);
    pins = '0;
    step();

    // R6/R9: coincident pin rise and route rewrite for line 3 (at 7)
    @(negedge clk);
    pins[pin_bit(10, 0)] = 1'b1;
    we = 1'b1; idx = 2'd3; val = 8'd2;
    @(negedge clk); we = 1'b0;
    check("R9 coincident: old route first", irq, 16'h0080);
    step();
    check("R6 coincident: new route next", irq, 16'h0004);
    pins[pin_bit(1, 1)] = 1'b1;   // line 1 still at 5
    step();
    check("R6 other routes kept", irq, 16'h0024);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule